// File: doc/BRIEF.md
# 8-bit Timer with Compare-Clear and Pulse-Width Modes

An 8-bit up-counter driven by a selectable clock divider. It holds one compare value and drives one waveform output. Three counting modes are available. In compare-clear mode the counter restarts from zero at each match, so it works as a programmable-period divider or square-wave source. The two single-slope pulse-width modes end the period at either 0xFF or the compare value.

In compare-clear mode, writes to the compare value reach the comparator immediately. In the pulse-width modes, writes are held in a buffer and take effect at the next period start. Two sticky event flags report compare matches and counter wraps. Each flag is cleared by pulsing its clear input. The waveform drives the pin only when the pin is configured as an output and a connected output mode is chosen.

Top module: `pwm_timer8`

## Requirements
- R1: With `mode_sel`=0 (compare-clear), the count rises by one on every timer tick, and on a tick where it equals the active compare value it becomes 0x00; between ticks it holds.
- R2: In compare-clear mode a compare write is active from the next cycle; if it is below the current count, no match occurs until the count has run through 0xFF and wrapped to 0x00.
- R3: In compare-clear mode `wave_mode` 1 toggles the waveform on each match, 2 clears it, 3 sets it; with compare value 0 and divide-by-1 the waveform toggles on every clock.
- R4: `clk_sel` picks the tick rate: 0 stopped, 1 every clock, 2 every 8, 3 every 64, 4 every 256, 5 every 1024, 6 and 7 stopped.
- R5: Any change of `clk_sel` restarts the divider, so the first tick under the new setting comes a full divide period after the change cycle.
- R6: `ovf_flag` sets on the tick where the count goes from its top to 0x00; the top is 0xFF in modes 0, 1 and 3 and the active compare value in mode 2.
- R7: `cmp_flag` sets on every tick where the count equals the active compare value.
- R8: A flag stays set until a cycle with its clear input high; if an event for that flag occurs in the same cycle, the flag stays set.
- R9: With `mode_sel`=1 (or 3), the count runs 0x00 to 0xFF and restarts at 0x00.
- R10: With `mode_sel`=2, the count runs 0x00 up to the active compare value and restarts at 0x00.
- R11: In the pulse-width modes `wave_mode` 2 sets the waveform at the restart and clears it on a match; 3 clears it at the restart and sets it on a match; the restart wins when both coincide; after reset the waveform is low.
- R12: In the pulse-width modes a compare write goes to a buffer that becomes active on the restart tick, or on any non-tick cycle while the count is 0x00.
- R13: `wave_oe` is high when `pin_dir` is 1 and the output mode is connected: any nonzero `wave_mode` in mode 0, or `wave_mode` 2 or 3 in the pulse-width modes. `wave_pin` is the waveform gated by `wave_oe`.
- R14: After reset the count, both flags, the waveform and the compare value are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 0 compare-clear, 1 PWM top 0xFF, 2 PWM top = compare, 3 same as 1 |
| wave_mode | input | 2 | Output action select (0 disconnected) |
| clk_sel | input | 3 | Divider select |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value to write |
| pin_dir | input | 1 | 1 = pin is an output |
| clr_cmp_flag | input | 1 | Clears the compare flag |
| clr_ovf_flag | input | 1 | Clears the wrap flag |
| count | output | 8 | Counter value |
| wave_pin | output | 1 | Gated waveform |
| wave_oe | output | 1 | Output enable for the pin |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
A table walks compare-clear runs with compare values 0, 4, 9 and 200 and tick counts chosen on both sides of a toggle, which separates correct period length from off-by-one periods. Pulse-width runs sample the count before and after the compare value in both polarities, and also inside the first period, which exposes a wrong polarity, a wrong restart priority or a missing initial low. Directed runs lower the compare value below the count to prove the wrap-around miss. They also write a new duty mid-period to show the buffer holds until the restart. They switch the divider mid-period to show that its count restarts, and they clear a flag on the cycle of a new event.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    TM_CTC      = 2'd0,
    TM_PWM_FULL = 2'd1,
    TM_PWM_CMP  = 2'd2,
    TM_PWM_ALT  = 2'd3
  } tmode_e;

  function automatic logic is_pwm(input tmode_e m);
    return m != TM_CTC;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [2:0]       sel_prev;
  logic [PRE_W-1:0] lim;
  logic             en;
  logic             chg;

  always_comb begin
    en  = 1'b1;
    lim = '0;
    case (clk_sel)
      3'd1:    lim = PRE_W'(0);
      3'd2:    lim = PRE_W'(7);
      3'd3:    lim = PRE_W'(63);
      3'd4:    lim = PRE_W'(255);
      3'd5:    lim = PRE_W'(1023);
      default: en  = 1'b0;
    endcase
  end

  assign chg  = clk_sel != sel_prev;
  assign tick = en && !chg && (cnt_q == lim);

  always_ff @(posedge clk) begin
    sel_prev <= clk_sel;
    if (rst || chg || !en || cnt_q == lim) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + PRE_W'(1);
  end

  // R4
  no_double_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && clk_sel != 3'd1) |=> !tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmode_e       mode,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         clr_cmp,
  input  logic         clr_ovf,
  output logic [W-1:0] count_q,
  output logic         match_ev,
  output logic         wrap_ev,
  output logic         cmp_flag_q,
  output logic         ovf_flag_q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cmp_buf, cmp_act, top;
  logic         ctc;

  assign ctc      = (mode == TM_CTC);
  assign top      = (mode == TM_PWM_CMP) ? cmp_act : MAXV;
  assign match_ev = tick && (count_q == cmp_act);
  assign wrap_ev  = tick && (count_q == top);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      cmp_buf    <= '0;
      cmp_act    <= '0;
      cmp_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (tick) begin
        if (wrap_ev || (ctc && match_ev)) count_q <= '0;
        else                              count_q <= count_q + W'(1);
      end
      if (cmp_wr) cmp_buf <= cmp_wdata;
      if (ctc) begin
        if (cmp_wr) cmp_act <= cmp_wdata;
      end else if (wrap_ev || (count_q == '0 && !tick)) begin
        cmp_act <= cmp_buf;
      end
      cmp_flag_q <= match_ev || (cmp_flag_q && !clr_cmp);
      ovf_flag_q <= wrap_ev  || (ovf_flag_q && !clr_ovf);
    end
  end

  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
  // R1
  ctc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && ctc && count_q == cmp_act) |=> (count_q == '0));
  // R6
  ovf_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count_q == MAXV && mode != TM_PWM_CMP) |=> ovf_flag_q);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_cmp && !tick) |=> !cmp_flag_q);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tmode_e     mode,
  input  logic [1:0] out_mode,
  input  logic       match_ev,
  input  logic       wrap_ev,
  output logic       wave_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
    end else if (!is_pwm(mode)) begin
      if (match_ev) begin
        case (out_mode)
          2'd1:    wave_q <= !wave_q;
          2'd2:    wave_q <= 1'b0;
          2'd3:    wave_q <= 1'b1;
          default: wave_q <= wave_q;
        endcase
      end
    end else if (out_mode[1]) begin
      if (wrap_ev)       wave_q <= !out_mode[0];
      else if (match_ev) wave_q <= out_mode[0];
    end
  end

  // R11
  pwm_restart_set_chk: assert property (@(posedge clk) disable iff (rst)
    (is_pwm(mode) && out_mode == 2'd2 && wrap_ev) |=> wave_q);
  // R3
  ctc_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_pwm(mode) && out_mode == 2'd1 && match_ev) |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       wave_mode,
  input  logic [2:0]       clk_sel,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             pin_dir,
  input  logic             clr_cmp_flag,
  input  logic             clr_ovf_flag,
  output logic [CNT_W-1:0] count,
  output logic             wave_pin,
  output logic             wave_oe,
  output logic             cmp_flag,
  output logic             ovf_flag
);
  tmode_e mode;
  logic   tick, match_ev, wrap_ev, wave_q, connected;

  assign mode = tmode_e'(mode_sel);

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick(tick)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .clr_cmp(clr_cmp_flag), .clr_ovf(clr_ovf_flag),
    .count_q(count), .match_ev(match_ev), .wrap_ev(wrap_ev),
    .cmp_flag_q(cmp_flag), .ovf_flag_q(ovf_flag)
  );

  tmr_wave u_wave (
    .clk(clk), .rst(rst), .mode(mode), .out_mode(wave_mode),
    .match_ev(match_ev), .wrap_ev(wrap_ev), .wave_q(wave_q)
  );

  assign connected = is_pwm(mode) ? wave_mode[1] : (wave_mode != 2'd0);
  assign wave_oe   = pin_dir && connected;
  assign wave_pin  = wave_q && wave_oe;

  // R13
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_dir |-> !wave_pin);
endmodule

// File: tb/pwm_timer8_test.sv
module pwm_timer8_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = '0, wave_mode = '0;
  logic [2:0] clk_sel = '0;
  logic       cmp_wr = 1'b0, pin_dir = 1'b1;
  logic [7:0] cmp_wdata = '0;
  logic       clr_cmp_flag = 1'b0, clr_ovf_flag = 1'b0;
  logic [7:0] count;
  logic       wave_pin, wave_oe, cmp_flag, ovf_flag;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  pwm_timer8 uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .wave_mode(wave_mode),
    .clk_sel(clk_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .pin_dir(pin_dir), .clr_cmp_flag(clr_cmp_flag), .clr_ovf_flag(clr_ovf_flag),
    .count(count), .wave_pin(wave_pin), .wave_oe(wave_oe),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [1:0] om;
    logic [7:0] cv;
    logic [9:0] ticks;
    logic [7:0] ecnt;
    logic       ewave;
    logic       eoe;
  } vec_t;

  // mode, wave_mode, compare, ticks at divide-by-1, count, wave_pin, wave_oe
  localparam vec_t VECS [15] = '{
    '{2'd0, 2'd1, 8'd9,   10'd25,  8'd5,   1'b0, 1'b1},
    '{2'd0, 2'd1, 8'd9,   10'd37,  8'd7,   1'b1, 1'b1},
    '{2'd0, 2'd1, 8'd0,   10'd5,   8'd0,   1'b1, 1'b1},
    '{2'd0, 2'd1, 8'd0,   10'd6,   8'd0,   1'b0, 1'b1},
    '{2'd0, 2'd2, 8'd4,   10'd7,   8'd2,   1'b0, 1'b1},
    '{2'd0, 2'd3, 8'd4,   10'd7,   8'd2,   1'b1, 1'b1},
    '{2'd1, 2'd2, 8'd99,  10'd300, 8'd44,  1'b1, 1'b1},
    '{2'd1, 2'd2, 8'd99,  10'd400, 8'd144, 1'b0, 1'b1},
    '{2'd1, 2'd3, 8'd99,  10'd300, 8'd44,  1'b0, 1'b1},
    '{2'd1, 2'd3, 8'd99,  10'd400, 8'd144, 1'b1, 1'b1},
    '{2'd1, 2'd2, 8'd99,  10'd50,  8'd50,  1'b0, 1'b1},
    '{2'd2, 2'd0, 8'd19,  10'd45,  8'd5,   1'b0, 1'b0},
    '{2'd0, 2'd0, 8'd200, 10'd255, 8'd54,  1'b0, 1'b0},
    '{2'd1, 2'd1, 8'd99,  10'd300, 8'd44,  1'b0, 1'b0},
    '{2'd3, 2'd2, 8'd99,  10'd400, 8'd144, 1'b0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] md, input logic [1:0] om, input logic [7:0] cv);
    rst = 1'b1; mode_sel = md; wave_mode = om; clk_sel = 3'd0; pin_dir = 1'b1;
    cmp_wr = 1'b0; clr_cmp_flag = 1'b0; clr_ovf_flag = 1'b0;
    step(2);
    rst = 1'b0; cmp_wr = 1'b1; cmp_wdata = cv;
    step(1);
    cmp_wr = 1'b0;
    step(1);
  endtask

  task automatic run(input int k);
    clk_sel = 3'd1;
    step(1);
    step(k);
  endtask

  initial begin
    step(1);
    // R14 reset state
    setup(2'd0, 2'd1, 8'd9);
    check("R14 count", count, 0);
    check("R14 cmp_flag", cmp_flag, 0);
    check("R14 ovf_flag", ovf_flag, 0);
    check("R14 wave_pin", wave_pin, 0);

    // table: R1 R3 R9 R10 R11 R13
    for (int i = 0; i < 15; i++) begin
      setup(VECS[i].md, VECS[i].om, VECS[i].cv);
      run(int'(VECS[i].ticks));
      check($sformatf("R1/R9/R10 vec%0d count", i), count, int'(VECS[i].ecnt));
      check($sformatf("R3/R11 vec%0d wave", i), wave_pin, int'(VECS[i].ewave));
      check($sformatf("R13 vec%0d oe", i), wave_oe, int'(VECS[i].eoe));
    end

    // R2 unbuffered compare lowered below the count
    setup(2'd0, 2'd1, 8'd50);
    run(40);
    check("R1 count before write", count, 40);
    cmp_wr = 1'b1; cmp_wdata = 8'd10;
    step(1);
    cmp_wr = 1'b0;
    step(214);
    check("R2 runs to 0xFF", count, 255);
    check("R2 no match yet", cmp_flag, 0);
    check("R6 no wrap yet", ovf_flag, 0);
    step(1);
    check("R2 wrapped", count, 0);
    check("R6 wrap flag", ovf_flag, 1);
    step(10);
    check("R2 reaches new compare", count, 10);
    step(1);
    check("R2 cleared at new compare", count, 0);
    check("R7 match flag", cmp_flag, 1);

    // R8 clearing and same-cycle priority
    clr_cmp_flag = 1'b1;
    step(1);
    clr_cmp_flag = 1'b0;
    check("R8 cleared", cmp_flag, 0);
    step(9);
    check("R1 count at compare", count, 10);
    clr_cmp_flag = 1'b1;
    step(1);
    clr_cmp_flag = 1'b0;
    check("R8 event beats clear", cmp_flag, 1);
    clr_ovf_flag = 1'b1;
    step(1);
    clr_ovf_flag = 1'b0;
    check("R8 wrap flag cleared", ovf_flag, 0);

    // R4 / R5 divider
    setup(2'd0, 2'd0, 8'd255);
    clk_sel = 3'd2;
    step(8);
    check("R4 div8 before tick", count, 0);
    step(1);
    check("R4 div8 first tick", count, 1);
    step(8);
    check("R4 div8 second tick", count, 2);
    step(3);
    clk_sel = 3'd3;
    step(64);
    check("R5 restart no early tick", count, 2);
    step(1);
    check("R5 tick after full period", count, 3);
    clk_sel = 3'd0;
    step(100);
    check("R4 stopped", count, 3);

    // R12 buffered duty
    setup(2'd1, 2'd2, 8'd99);
    run(300);
    cmp_wr = 1'b1; cmp_wdata = 8'd20;
    step(1);
    cmp_wr = 1'b0;
    step(10);
    check("R12 count mid period", count, 55);
    check("R12 old duty kept", wave_pin, 1);
    step(211);
    check("R12 new duty active high", wave_pin, 1);
    step(15);
    check("R12 count next period", count, 25);
    check("R12 new duty low", wave_pin, 0);

    // R10 / R6 wrap at compare top
    setup(2'd2, 2'd0, 8'd19);
    run(19);
    check("R10 at top", count, 19);
    check("R6 no wrap before top", ovf_flag, 0);
    step(1);
    check("R10 restart", count, 0);
    check("R6 wrap at compare top", ovf_flag, 1);
    check("R7 match at top", cmp_flag, 1);

    // R13 pin direction gating
    setup(2'd0, 2'd1, 8'd0);
    run(1);
    check("R3 toggled", wave_pin, 1);
    pin_dir = 1'b0;
    #1;
    check("R13 pin off", wave_pin, 0);
    check("R13 oe off", wave_oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule